// File: doc/BRIEF.md
# Parallel Life Cellular Automaton Grid

This block holds a small two-dimensional grid of Conway's Life cells. Each cell has its own flip-flop, and on a generation step every cell computes its next state in the same clock cycle. Neighbour counts wrap around the grid edges, so the grid behaves as a torus.

The same storage also serves as a set of ring shift registers, one per row. In snapshot mode each row rotates by one column per clock, and the bit about to leave the last column shows on that row's serial output. After one full rotation a frame has been read out and the grid is back where it started. In load mode the same path accepts a serial pattern: each row's serial input takes the place of the bit that would have wrapped around.

A one-cycle done pulse marks each completed run of COLS shift clocks. A step request that arrives while shifting is dropped. Display memory, pixel timing and any serial receiver sit outside this block.

Top module: `life_grid`

## Requirements
- R1: After reset every cell is dead (0) and `done_o` is low.
- R2: In run mode (`mode_i` = 0, or the unused code 3), a high `step_i` at a clock edge replaces every cell at once. A cell becomes live when it has exactly 3 live neighbours. A live cell also stays live when it has exactly 2. Every other cell becomes dead.
- R3: Neighbours wrap around the edges. Row 0 is adjacent to row ROWS-1, and column 0 is adjacent to column COLS-1.
- R4: In run mode with `step_i` low, no cell changes.
- R5: In snapshot mode (`mode_i` = 1), every clock moves each cell of row r from column c to column c+1. Column 0 takes the old value of column COLS-1.
- R6: After COLS consecutive snapshot clocks, the grid is identical to its state before the sequence began.
- R7: In load mode (`mode_i` = 2), every clock shifts each row the same way, but column 0 of row r takes `ser_in_i[r]`. After COLS load clocks, the first bit presented sits in column COLS-1.
- R8: `ser_out_o[r]` always shows column COLS-1 of row r. Over a snapshot it therefore presents the columns in the order COLS-1 down to 0.
- R9: `done_o` is high for exactly one cycle, right after the clock edge that completes each group of COLS consecutive shift clocks. Leaving shift mode restarts the count.
- R10: `step_i` has no effect while `mode_i` selects snapshot or load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_i | input | 1 | Generation step request (run mode only) |
| mode_i | input | 2 | 0 run, 1 snapshot rotate, 2 serial load, 3 treated as run |
| ser_in_i | input | ROWS | Serial load bit per row |
| ser_out_o | output | ROWS | Current last-column bit per row |
| done_o | output | 1 | One-cycle pulse after each group of COLS shifts |

## Verification
The embedded assertions check every cycle that an idle run cycle leaves the grid unchanged. They also check that rotation and load feed column 0 from the correct source, that a step asserted during rotation cannot change the population, and that the shift counter stays in range and clears when shifting stops. The Life rule itself, with its toroidal wrap, can only be judged against the bench's reference model across stepped generations. The same holds for the full-rotation identity and the exact timing of the done pulse.

// File: rtl/life_pkg.sv
package life_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_SNAP = 2'd1,
    MODE_LOAD = 2'd2
  } mode_e;

  // population count of the eight surrounding cells
  function automatic logic [3:0] pop8(input logic [7:0] v);
    logic [3:0] s;
    s = '0;
    for (int i = 0; i < 8; i++) s = s + {3'b000, v[i]};
    return s;
  endfunction

endpackage

// File: rtl/life_cell.sv
module life_cell
  import life_pkg::*;
(
  input  logic       alive_i,
  input  logic [7:0] nbr_i,
  output logic       next_o
);

  logic [3:0] n_live;

  always_comb begin
    n_live = pop8(nbr_i);
    next_o = (n_live == 4'd3) | (alive_i & (n_live == 4'd2));
  end

endmodule

// File: rtl/shift_seq.sv
module shift_seq #(
  parameter int COLS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en_i,
  output logic done_o
);

  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;
  localparam logic [CW-1:0] LAST = CW'(COLS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (!shift_en_i) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d  = '0;
      done_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  // R9: counter never passes the last column index
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R9: a done pulse only follows a shift clock
  p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(shift_en_i));

  // R9: leaving shift mode restarts the count
  p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en_i |=> (cnt_q == '0 && !done_q));

endmodule

// File: rtl/life_grid.sv
module life_grid
  import life_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_i,
  input  logic [1:0]      mode_i,
  input  logic [ROWS-1:0] ser_in_i,
  output logic [ROWS-1:0] ser_out_o,
  output logic            done_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // mode decode
  logic shift_en, load_sel, step_en, cell_en;

  always_comb begin
    shift_en = (mode_i == MODE_SNAP) || (mode_i == MODE_LOAD);
    load_sel = (mode_i == MODE_LOAD);
    step_en  = step_i && !shift_en;
    cell_en  = shift_en || step_en;
  end

  // cell storage
  logic [ROWS-1:0][COLS-1:0] cell_q, cell_d, life_nxt, shift_nxt;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam int RU = (r + ROWS - 1) % ROWS;
    localparam int RD = (r + 1) % ROWS;

    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int CL = (c + COLS - 1) % COLS;
      localparam int CR = (c + 1) % COLS;

      life_cell u_cell (
        .alive_i (cell_q[r][c]),
        .nbr_i   ({cell_q[RU][CL], cell_q[RU][c], cell_q[RU][CR],
                   cell_q[r][CL],                 cell_q[r][CR],
                   cell_q[RD][CL], cell_q[RD][c], cell_q[RD][CR]}),
        .next_o  (life_nxt[r][c])
      );

      if (c == 0) begin : g_head
        assign shift_nxt[r][c] = load_sel ? ser_in_i[r] : cell_q[r][COLS-1];
      end else begin : g_body
        assign shift_nxt[r][c] = cell_q[r][c-1];
      end
    end

    assign ser_out_o[r] = cell_q[r][COLS-1];

    // R5: rotation feeds column 0 from the last column
    p_rotate_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
      (shift_en && !load_sel) |=> cell_q[r][0] == $past(cell_q[r][COLS-1]));

    // R7: load feeds column 0 from the serial input
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
      load_sel |=> cell_q[r][0] == $past(ser_in_i[r]));
  end

  always_comb begin
    if (shift_en)     cell_d = shift_nxt;
    else if (step_en) cell_d = life_nxt;
    else              cell_d = cell_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  cell_q <= '0;
    else if (cell_en) cell_q <= cell_d;
  end

  shift_seq #(.COLS(COLS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .shift_en_i (shift_en),
    .done_o     (done_o)
  );

  // R4: an idle run cycle holds the grid
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!shift_en && !step_i) |=> $stable(cell_q));

  // R10: a step during rotation cannot alter the population
  p_no_step_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (shift_en && !load_sel && step_i) |=> $countones(cell_q) == $past($countones(cell_q)));

endmodule

// File: tb/life_grid_test.sv
`timescale 1ns/1ps
module life_grid_test;

  localparam int ROWS = 8;
  localparam int COLS = 8;
  typedef logic [ROWS-1:0][COLS-1:0] grid_t;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            step_i;
  logic [1:0]      mode_i;
  logic [ROWS-1:0] ser_in_i;
  logic [ROWS-1:0] ser_out_o;
  logic            done_o;

  int checks = 0;
  int errors = 0;
  grid_t mdl, snap, pat;

  always #2.5 clk = ~clk;

  life_grid #(.ROWS(ROWS), .COLS(COLS)) uut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .mode_i(mode_i),
    .ser_in_i(ser_in_i), .ser_out_o(ser_out_o), .done_o(done_o)
  );

  function automatic grid_t life_ref(grid_t g);
    grid_t n;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        int cnt = 0;
        for (int dr = -1; dr <= 1; dr++)
          for (int dc = -1; dc <= 1; dc++)
            if (dr != 0 || dc != 0)
              cnt += g[(r + dr + ROWS) % ROWS][(c + dc + COLS) % COLS];
        n[r][c] = (cnt == 3) || (g[r][c] && cnt == 2);
      end
    return n;
  endfunction

  function automatic grid_t rot_ref(grid_t g, int k);
    grid_t n;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        n[r][c] = g[r][(c - k + COLS * 4) % COLS];
    return n;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // full rotation readout; optionally holds step high throughout
  task automatic snapshot(output grid_t g, input bit with_step);
    mode_i = 2'd1;
    step_i = with_step;
    for (int c = 0; c < COLS; c++) begin
      for (int r = 0; r < ROWS; r++) g[r][COLS-1-c] = ser_out_o[r];
      chk("R9 no early done", {63'd0, done_o}, 64'd0);
      @(posedge clk); @(negedge clk);
    end
    chk("R9 done after COLS shifts", {63'd0, done_o}, 64'd1);
    mode_i = 2'd0;
    step_i = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R9 single pulse", {63'd0, done_o}, 64'd0);
  endtask

  task automatic load(input grid_t g);
    mode_i = 2'd2;
    for (int c = 0; c < COLS; c++) begin
      for (int r = 0; r < ROWS; r++) ser_in_i[r] = g[r][COLS-1-c];
      @(posedge clk); @(negedge clk);
    end
    chk("R9 done after load", {63'd0, done_o}, 64'd1);
    mode_i = 2'd0;
    ser_in_i = '0;
    @(posedge clk); @(negedge clk);
    mdl = g;
  endtask

  task automatic do_step();
    mode_i = 2'd0;
    step_i = 1'b1;
    @(posedge clk); @(negedge clk);
    step_i = 1'b0;
    mdl = life_ref(mdl);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; step_i = 1'b0; mode_i = 2'd0; ser_in_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 done low", {63'd0, done_o}, 64'd0);
    mdl = '0;
    snapshot(snap, 1'b0);
    chk("R1 grid clear", 64'(snap), 64'(grid_t'('0)));

    // R7 / R8 load and read back
    pat = grid_t'({$urandom, $urandom});
    load(pat);
    snapshot(snap, 1'b0);
    chk("R7 R8 load readback", 64'(snap), 64'(pat));
    snapshot(snap, 1'b0);
    chk("R6 rotation restores grid", 64'(snap), 64'(pat));

    // R4 idle cycles hold
    repeat (7) @(negedge clk);
    snapshot(snap, 1'b0);
    chk("R4 idle hold", 64'(snap), 64'(mdl));

    // R3 blinker across the corner wraps
    pat = '0;
    pat[0][COLS-1] = 1'b1; pat[0][0] = 1'b1; pat[0][1] = 1'b1;
    load(pat);
    do_step();
    pat = '0;
    pat[ROWS-1][0] = 1'b1; pat[0][0] = 1'b1; pat[1][0] = 1'b1;
    snapshot(snap, 1'b0);
    chk("R3 wrapped blinker", 64'(snap), 64'(pat));
    chk("R2 model agrees", 64'(mdl), 64'(pat));

    // R2 random generations
    for (int it = 0; it < 20; it++) begin
      pat = grid_t'({$urandom, $urandom} & {$urandom, $urandom});
      load(pat);
      for (int s = 0; s <= int'($urandom % 3); s++) do_step();
      snapshot(snap, 1'b0);
      chk("R2 generation", 64'(snap), 64'(mdl));
    end

    // R10 step ignored during shifting
    snapshot(snap, 1'b1);
    chk("R10 step during snapshot", 64'(snap), 64'(mdl));
    snapshot(snap, 1'b0);
    chk("R10 grid after snapshot", 64'(snap), 64'(mdl));

    // R5 / R9 partial rotation then restart of the count
    pat = grid_t'({$urandom, $urandom});
    load(pat);
    mode_i = 2'd1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); @(negedge clk);
    end
    chk("R9 no done on partial", {63'd0, done_o}, 64'd0);
    mode_i = 2'd0;
    @(posedge clk); @(negedge clk);
    mdl = rot_ref(pat, 3);
    chk("R8 last column after 3 shifts", 64'(ser_out_o), 64'(ROWS'(0)) |
        64'({pat[7][COLS-4], pat[6][COLS-4], pat[5][COLS-4], pat[4][COLS-4],
             pat[3][COLS-4], pat[2][COLS-4], pat[1][COLS-4], pat[0][COLS-4]}));
    snapshot(snap, 1'b0);
    chk("R5 rotated by three", 64'(snap), 64'(mdl));

    finish_run();
  end

endmodule